// File: doc/BRIEF.md
# Banked GPIO Register Controller

A memory-mapped GPIO controller that splits its pins into banks of 32 and gives every bank the same eight word registers. Software reaches them over a plain 32-bit request/response bus. The block drives each pin's output value and output enable, and it brings the pin inputs in through a two-flop synchronizer so that they can be read back. It also holds the interrupt configuration for each pin and hands that configuration to an external interrupt sense unit. Pulses coming back from the sense unit are latched into a status register that software clears by writing ones.

The `WIDTHS` parameter sets how many pins each bank implements. A bank of width zero is a placeholder: it still takes up its own 32-byte address window, but it holds no state. Bits above a bank's width always read as zero.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: The byte address of a register is bank*32 + index*4. The indices are 0 open-drain, 1 data, 2 direction, 3 edge polarity, 4 both-edges, 5 interrupt enable, 6 level mode and 7 status. Each configuration register reads back what was written to it. Bit k of bank b appears at bit b*32+k of the matching `cfg_*` output, and that output changes only when the register is written.
- R2: `req_ready` is always 1. Every accepted request produces `rsp_valid` in the next cycle, together with `rsp_rdata` for reads. A write is visible to reads and at the outputs from the next cycle.
- R3: Reset clears every register. Every implemented pin then drives 0 with its output enable at 1.
- R4: A direction bit of 1 makes the pin an input, with `pin_oe` at 0. A direction bit of 0 makes the pin an output that drives the data bit on `pin_out`.
- R5: On an output pin whose open-drain bit is 1, `pin_out` is 0 and `pin_oe` is the inverse of the data bit. A data bit of 1 releases the pin and a data bit of 0 pulls it low.
- R6: A data read returns the synchronized pin level for input bits and the stored value for output bits. The first two reads issued in the cycle a pin changes return the old level; the third read returns the new one.
- R7: A pulse on `irq_set` sets the status bit. Writing 1 to a status bit clears it and writing 0 leaves it as it was. If a set pulse and a clear arrive in the same cycle, the bit stays set.
- R8: Bits at or above a bank's width read as 0. Writes to them are ignored, set pulses are ignored, and their `pin_oe` and `cfg_*` bits stay at 0.
- R9: A bank of width 0 reads 0 in all eight registers and ignores writes. The bank that follows it keeps its normal address.
- R10: Addresses above the last bank read 0, and writes to them change no register of any bank.
- R11: A data write replaces every implemented bit; the block has no set or clear registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW-2 | Word address, which is byte address bits AW-1:2 |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data |
| pin_in | input | BANKS*32 | Pin input levels |
| pin_out | output | BANKS*32 | Pin output values |
| pin_oe | output | BANKS*32 | Pin output enables |
| cfg_edge_pol | output | BANKS*32 | Edge polarity per pin (1 = rising/high) |
| cfg_edge_both | output | BANKS*32 | Sense both edges per pin |
| cfg_irq_en | output | BANKS*32 | Interrupt enable per pin |
| cfg_level | output | BANKS*32 | Level (1) or edge (0) sensing per pin |
| irq_set | input | BANKS*32 | Status set pulses from the sense unit |

## Verification
Register writes, status sets and status clears take effect at the clock edge that accepts them. The pin outputs and `cfg_*` vectors therefore change one edge after a write, and the bench samples them at the following falling edge. A read response is registered, so it is sampled at the falling edge after the request edge. Pin inputs pass through two synchronizer flops before they reach that response register. The bench therefore checks that the two reads issued right after a pin change still return the old level and that only the third returns the new one.

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int BANKS = 3,
  parameter logic [6*BANKS-1:0] WIDTHS = {6'd12, 6'd0, 6'd32},
  localparam int PINS = BANKS * 32,
  localparam int AW = $clog2(BANKS) + 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:2]   req_addr,
  input  logic [31:0]     req_wdata,
  output logic            rsp_valid,
  output logic [31:0]     rsp_rdata,
  input  logic [PINS-1:0] pin_in,
  output logic [PINS-1:0] pin_out,
  output logic [PINS-1:0] pin_oe,
  output logic [PINS-1:0] cfg_edge_pol,
  output logic [PINS-1:0] cfg_edge_both,
  output logic [PINS-1:0] cfg_irq_en,
  output logic [PINS-1:0] cfg_level,
  input  logic [PINS-1:0] irq_set
);
  logic [PINS-1:0] od_q, data_q, dir_q, pol_q, both_q, en_q, lvl_q, stat_q;
  logic [PINS-1:0] impl, sync1, sync2, rd_data;
  logic [AW-6:0]   bsel;
  logic [2:0]      rsel;
  logic [31:0]     rd;

  assign bsel = req_addr[AW-1:5];
  assign rsel = req_addr[4:2];
  assign req_ready = 1'b1;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam int W = int'(WIDTHS[6*b +: 6]);
    logic        hit;
    logic [31:0] m, clr;
    assign m   = (W >= 32) ? 32'hFFFF_FFFF : ((32'd1 << W) - 32'd1);
    assign hit = req_valid && req_write && (int'(bsel) == b);
    assign clr = (hit && rsel == 3'd7) ? req_wdata : 32'd0;
    assign impl[b*32 +: 32] = m;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        od_q[b*32 +: 32]   <= '0;
        data_q[b*32 +: 32] <= '0;
        dir_q[b*32 +: 32]  <= '0;
        pol_q[b*32 +: 32]  <= '0;
        both_q[b*32 +: 32] <= '0;
        en_q[b*32 +: 32]   <= '0;
        lvl_q[b*32 +: 32]  <= '0;
        stat_q[b*32 +: 32] <= '0;
      end else begin
        if (hit) begin
          case (rsel)
            3'd0: od_q[b*32 +: 32]   <= req_wdata & m;
            3'd1: data_q[b*32 +: 32] <= req_wdata & m;
            3'd2: dir_q[b*32 +: 32]  <= req_wdata & m;
            3'd3: pol_q[b*32 +: 32]  <= req_wdata & m;
            3'd4: both_q[b*32 +: 32] <= req_wdata & m;
            3'd5: en_q[b*32 +: 32]   <= req_wdata & m;
            3'd6: lvl_q[b*32 +: 32]  <= req_wdata & m;
            default: ;
          endcase
        end
        stat_q[b*32 +: 32] <= ((stat_q[b*32 +: 32] & ~clr) | irq_set[b*32 +: 32]) & m;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end
  end

  assign rd_data = ((data_q & ~dir_q) | (sync2 & dir_q)) & impl;

  always_comb begin
    rd = '0;
    if (int'(bsel) < BANKS) begin
      case (rsel)
        3'd0: rd = od_q[int'(bsel)*32 +: 32];
        3'd1: rd = rd_data[int'(bsel)*32 +: 32];
        3'd2: rd = dir_q[int'(bsel)*32 +: 32];
        3'd3: rd = pol_q[int'(bsel)*32 +: 32];
        3'd4: rd = both_q[int'(bsel)*32 +: 32];
        3'd5: rd = en_q[int'(bsel)*32 +: 32];
        3'd6: rd = lvl_q[int'(bsel)*32 +: 32];
        default: rd = stat_q[int'(bsel)*32 +: 32];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= (req_valid && !req_write) ? rd : 32'd0;
    end
  end

  assign pin_out       = data_q & ~od_q & ~dir_q;
  assign pin_oe        = impl & ~dir_q & ~(od_q & data_q);
  assign cfg_edge_pol  = pol_q;
  assign cfg_edge_both = both_q;
  assign cfg_irq_en    = en_q;
  assign cfg_level     = lvl_q;
endmodule

module gpio_bank_ctrl_chk #(
  parameter int PINS = 96
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_write,
  input logic            rsp_valid,
  input logic [PINS-1:0] pin_out,
  input logic [PINS-1:0] pin_oe,
  input logic [PINS-1:0] od,
  input logic [PINS-1:0] dir,
  input logic [PINS-1:0] impl,
  input logic [PINS-1:0] stat,
  input logic [PINS-1:0] irq_set,
  input logic [PINS-1:0] cfg_irq_en
);
  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_stray_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_input_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & dir) == '0);
  assert_od_never_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & od) == '0);
  assert_unimpl_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe | stat | cfg_irq_en) & ~impl) == '0);
  assert_stat_rise_needs_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat & ~$past(stat) & ~$past(irq_set)) == '0);
  assert_cfg_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> $stable(cfg_irq_en));
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.PINS(PINS)) chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .pin_out(pin_out), .pin_oe(pin_oe), .od(od_q),
  .dir(dir_q), .impl(impl), .stat(stat_q), .irq_set(irq_set),
  .cfg_irq_en(cfg_irq_en)
);

// File: tb/gpio_bank_ctrl_test.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [6:2]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [95:0] pin_in = '0, irq_set = '0;
  logic [95:0] pin_out, pin_oe, cfg_edge_pol, cfg_edge_both, cfg_irq_en, cfg_level;
  int checks = 0, errors = 0;
  logic [31:0] r;

  always #10 clk = ~clk;

  gpio_bank_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .cfg_edge_pol(cfg_edge_pol),
    .cfg_edge_both(cfg_edge_both), .cfg_irq_en(cfg_irq_en),
    .cfg_level(cfg_level), .irq_set(irq_set)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a[6:2]; req_wdata = d;
    @(negedge clk);
    check("R2 write rsp_valid", {31'd0, rsp_valid}, 32'd1);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a[6:2];
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 read rsp_valid/ready", {30'd0, rsp_valid, req_ready}, 32'd3);
    d = rsp_rdata;
  endtask

  task automatic t_reset;
    rd(8'h04, r); check("R3 data after reset", r, 32'h0);
    check("R3 bank0 oe", pin_oe[31:0], 32'hFFFF_FFFF);
    check("R9 empty bank oe", pin_oe[63:32], 32'h0);
    check("R8 bank2 oe", pin_oe[95:64], 32'h0000_0FFF);
    check("R3 pin_out low", pin_out[31:0] | pin_out[95:64], 32'h0);
  endtask

  task automatic t_regmap;
    wr(8'h0C, 32'h1111_0001); wr(8'h10, 32'h2222_0002);
    wr(8'h14, 32'h3333_0003); wr(8'h18, 32'h4444_0004);
    rd(8'h0C, r); check("R1 edge pol readback", r, 32'h1111_0001);
    rd(8'h10, r); check("R1 both readback", r, 32'h2222_0002);
    rd(8'h14, r); check("R1 enable readback", r, 32'h3333_0003);
    rd(8'h18, r); check("R1 level readback", r, 32'h4444_0004);
    check("R1 cfg_edge_pol", cfg_edge_pol[31:0], 32'h1111_0001);
    check("R1 cfg_edge_both", cfg_edge_both[31:0], 32'h2222_0002);
    check("R1 cfg_irq_en", cfg_irq_en[31:0], 32'h3333_0003);
    check("R1 cfg_level", cfg_level[31:0], 32'h4444_0004);
    wr(8'h4C, 32'hFFFF_FFFF);
    rd(8'h4C, r); check("R8 bank2 masked readback", r, 32'h0000_0FFF);
    check("R8 bank2 cfg bits", cfg_edge_pol[95:64], 32'h0000_0FFF);
  endtask

  task automatic t_dir_data;
    wr(8'h04, 32'h0000_000F); wr(8'h04, 32'h0000_00F0);
    rd(8'h04, r); check("R11 data replaced", r, 32'h0000_00F0);
    check("R4 pin_out follows data", pin_out[31:0], 32'h0000_00F0);
    wr(8'h08, 32'h0000_FF00);
    check("R4 inputs released", pin_oe[31:0], 32'hFFFF_00FF);
    pin_in[15:8] = 8'hA5;
    rd(8'h04, r); check("R6 first read old", r, 32'h0000_00F0);
    rd(8'h04, r); check("R6 second read old", r, 32'h0000_00F0);
    rd(8'h04, r); check("R6 third read new", r, 32'h0000_A5F0);
  endtask

  task automatic t_open_drain;
    wr(8'h00, 32'h0000_0030);
    check("R5 od released oe", {28'd0, pin_oe[7:4]}, 32'hC);
    check("R5 od out", {28'd0, pin_out[7:4]}, 32'hC);
    wr(8'h04, 32'h0);
    check("R5 od pull low oe", {24'd0, pin_oe[7:0]}, 32'hFF);
    check("R5 od pull low out", {24'd0, pin_out[7:0]}, 32'h0);
    wr(8'h00, 32'h0); wr(8'h08, 32'h0);
  endtask

  task automatic t_status;
    irq_set[31:0] = 32'h0000_0103; irq_set[95:64] = 32'h0000_2004;
    @(negedge clk);
    irq_set = '0;
    rd(8'h1C, r); check("R7 set by pulse", r, 32'h0000_0103);
    rd(8'h5C, r); check("R8 status above width", r, 32'h0000_0004);
    wr(8'h1C, 32'h0000_0001);
    rd(8'h1C, r); check("R7 w1c", r, 32'h0000_0102);
    irq_set[1] = 1'b1;
    wr(8'h1C, 32'h0000_0002);
    irq_set = '0;
    rd(8'h1C, r); check("R7 set wins over clear", r, 32'h0000_0102);
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, r); check("R7 clear all", r, 32'h0);
  endtask

  task automatic t_empty_bank;
    for (int i = 0; i < 8; i++) wr(8'h20 + 8'(i*4), 32'hFFFF_FFFF);
    for (int i = 0; i < 8; i++) begin
      rd(8'h20 + 8'(i*4), r); check("R9 empty bank reads 0", r, 32'h0);
    end
    check("R9 empty bank cfg", cfg_irq_en[63:32] | pin_oe[63:32], 32'h0);
    wr(8'h54, 32'h0000_1234);
    rd(8'h54, r); check("R9 next bank at own window", r, 32'h0000_0234);
  endtask

  task automatic t_out_of_range;
    wr(8'h64, 32'h0000_FFFF); wr(8'h74, 32'h0000_FFFF);
    rd(8'h64, r); check("R10 beyond last bank", r, 32'h0);
    rd(8'h04, r); check("R10 bank0 data untouched", r, 32'h0);
    rd(8'h14, r); check("R10 bank0 enable untouched", r, 32'h3333_0003);
    check("R10 pins untouched", pin_out[31:0], 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_dir_data();
    t_open_drain();
    t_status();
    t_empty_bank();
    t_out_of_range();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule